// File: doc/BRIEF.md
# Transmit Credit Gate

This block sits in front of a transaction-layer transmitter and decides, one packet at a time, whether the link partner has advertised enough buffer space to accept the next packet. It takes a packed 36-bit snapshot of the available transmit credits and a request that names the packet class, whether a payload is attached and the payload length in dwords. From these it raises a registered grant or leaves the request stalled.

Each of the three packet classes (posted, non-posted, completion) has a header credit field and a data credit field in the snapshot. Header fields, and the narrow non-posted data field, saturate: the value seven stands for seven or more. A field that is all ones advertises infinite credit, and the gate never stalls on it. A strict mode raises the minimum for the non-posted fields. A build option supports systems that allocate only one non-posted credit: after a non-posted packet leaves, further non-posted packets wait until a completion is reported on a re-arm pulse.

The request side is a valid/ready stream. The requester raises `req_valid` and holds the class, payload flag and length stable until the transfer. `req_ready` is the grant. A transfer happens on a rising clock edge where both are high. Once granted, `req_ready` stays high until that transfer, whatever the credit snapshot does in the meantime. It drops for at least one cycle after every transfer, so the requester sees back-pressure between packets.

Top module: `txc_gate`

## Requirements
- R1: The credit vector carries these fields: completion data in bits 35:24, completion header in 23:21, non-posted data in 20:18, non-posted header in 17:15, posted data in 14:3 and posted header in 2:0. A request reads only the fields of its own class.
- R2: A request needs one header credit of its class. A header field of 0 blocks it. Any value from 1 to 7 admits it, and 7 means seven or more.
- R3: When `req_has_data` is 1, the request needs ceil(`req_len`/4) data credits of its class, so `req_len` = 0 needs none. The data field must be at least that number. When `req_has_data` is 0, the data field is not looked at.
- R4: A field that is all ones (7 in a 3-bit field, 4095 in a 12-bit field) is infinite and always satisfies its part of the check, whatever the length.
- R5: While `np_strict` is 1, a non-posted request needs a header field of 6 or more. If it carries data, its data field must also be 6 or more, in addition to covering the length. Other classes are not affected.
- R6: `req_class` encodes 0 = posted, 1 = non-posted and 2 = completion. The value 3 is reserved and is never granted.
- R7: The grant is registered. If `req_valid` is high with sufficient credit at rising edge N, `req_ready` rises just after edge N and not earlier.
- R8: Once high, `req_ready` stays high until a transfer (`req_valid` and `req_ready` both high at an edge), even if `req_valid` falls or credits vanish. It is low in the cycle after the transfer.
- R9: With `NP_ONE_CREDIT` = 1, a non-posted transfer blocks further non-posted grants until an `np_rearm` pulse has been seen. A pulse in the same cycle as a non-posted transfer is overridden. Posted and completion requests are unaffected. With `NP_ONE_CREDIT` = 0, `np_rearm` has no effect.
- R10: `stall` is high exactly when `req_valid` is high and `req_ready` is low. After reset `req_ready` is low and the non-posted path is armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_credits | input | 36 | Packed available-credit snapshot |
| np_strict | input | 1 | Raises the non-posted minimum to six |
| np_rearm | input | 1 | Pulse: a completion released the single non-posted credit |
| req_valid | input | 1 | A packet request is presented |
| req_ready | output | 1 | Registered grant; transfer when high with req_valid |
| req_class | input | 2 | Packet class of the request |
| req_has_data | input | 1 | The packet carries a payload |
| req_len | input | LEN_W | Payload length in dwords |
| stall | output | 1 | Request waiting for credit or re-arm |

## Verification
The bench builds the gate with `LEN_W` = 6 and `NP_ONE_CREDIT` = 1. The narrow length keeps the need between 0 and 16 data credits. A length sweep then crosses every rounding boundary and the 15/16 edge of the wide data fields, including the all-ones value. The single-credit build lets the same run show non-posted blocking, posted traffic passing during the block, re-arming, and the same-cycle transfer-versus-re-arm case. The sweep covers every header value 0 to 7, both strict settings, both payload flags and every class code, including the reserved one.

// File: rtl/txc_gate_pkg.sv
package txc_gate_pkg;

  // Field widths of the credit snapshot
  localparam int HDR_W   = 3;
  localparam int WDATA_W = 12;
  localparam int NDATA_W = 3;

  // Field positions; the order is fixed by the producer of the vector
  localparam int PH_LO  = 0;
  localparam int PD_LO  = PH_LO + HDR_W;
  localparam int NH_LO  = PD_LO + WDATA_W;
  localparam int ND_LO  = NH_LO + HDR_W;
  localparam int CH_LO  = ND_LO + NDATA_W;
  localparam int CD_LO  = CH_LO + HDR_W;
  localparam int CRED_W = CD_LO + WDATA_W;

  localparam int NUM_CLASSES = 3;

  typedef enum logic [1:0] {
    TXC_POSTED  = 2'd0,
    TXC_NONPOST = 2'd1,
    TXC_CPL     = 2'd2,
    TXC_RSVD    = 2'd3
  } txc_class_e;

  function automatic int txc_hdr_lo(int c);
    return (c == 0) ? PH_LO : (c == 1) ? NH_LO : CH_LO;
  endfunction

  function automatic int txc_dat_lo(int c);
    return (c == 0) ? PD_LO : (c == 1) ? ND_LO : CD_LO;
  endfunction

  function automatic int txc_dat_w(int c);
    return (c == 1) ? NDATA_W : WDATA_W;
  endfunction

endpackage

// File: rtl/txc_need.sv
// Converts a payload length in dwords into data credits (4 dwords each).
module txc_need #(
  parameter int LEN_W = 10
) (
  input  logic [LEN_W-1:0] len,
  output logic [LEN_W-2:0] need
);
  localparam int SUM_W = LEN_W + 1;

  logic [SUM_W-1:0] rounded;

  always_comb begin
    rounded = {1'b0, len} + SUM_W'(3);
    need    = rounded[SUM_W-1:2];
  end
endmodule

// File: rtl/txc_class_check.sv
// Decides whether one class's header and data fields cover a request.
module txc_class_check #(
  parameter int HDR_W  = 3,
  parameter int DATA_W = 12,
  parameter int NEED_W = 9,
  parameter int FLOOR  = 6
) (
  input  logic [HDR_W-1:0]  hdr_fld,
  input  logic [DATA_W-1:0] dat_fld,
  input  logic [NEED_W-1:0] need,
  input  logic              has_data,
  input  logic              strict_en,
  output logic              pass
);
  localparam int CMP_W = (DATA_W > NEED_W) ? DATA_W : NEED_W;
  localparam logic [HDR_W-1:0] HDR_FLOOR = HDR_W'(FLOOR);
  localparam logic [CMP_W-1:0] DAT_FLOOR = CMP_W'(FLOOR);

  logic             hdr_inf, dat_inf;
  logic             hdr_ok, dat_ok, dat_floor_ok;
  logic [CMP_W-1:0] dat_cmp, need_cmp;

  always_comb begin
    hdr_inf      = &hdr_fld;
    dat_inf      = &dat_fld;
    dat_cmp      = CMP_W'(dat_fld);
    need_cmp     = CMP_W'(need);
    hdr_ok       = hdr_inf || (strict_en ? (hdr_fld >= HDR_FLOOR)
                                         : (hdr_fld != '0));
    dat_floor_ok = !strict_en || (dat_cmp >= DAT_FLOOR);
    dat_ok       = !has_data || dat_inf || (dat_floor_ok && (dat_cmp >= need_cmp));
    pass         = hdr_ok && dat_ok;
  end
endmodule

// File: rtl/txc_grant_ctl.sv
// Registered grant with hold-until-transfer and the single-credit re-arm.
module txc_grant_ctl #(
  parameter bit NP_ONE_CREDIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_np,
  input  logic credit_ok,
  input  logic np_rearm,
  output logic grant
);
  logic grant_q;
  logic armed_q;
  logic np_armed;
  logic xfer;
  logic grant_d;

  always_comb begin
    np_armed = armed_q || !NP_ONE_CREDIT;
    xfer     = grant_q && req_valid;
    if (grant_q) grant_d = !req_valid;
    else         grant_d = req_valid && credit_ok && (!req_np || np_armed);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      grant_q <= grant_d;
      if (NP_ONE_CREDIT && xfer && req_np) armed_q <= 1'b0;
      else if (np_rearm)                   armed_q <= 1'b1;
    end
  end

  assign grant = grant_q;
endmodule

// File: rtl/txc_gate.sv
module txc_gate
  import txc_gate_pkg::*;
#(
  parameter int LEN_W          = 10,
  parameter int NP_FLOOR       = 6,
  parameter bit NP_ONE_CREDIT  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CRED_W-1:0] tx_credits,
  input  logic              np_strict,
  input  logic              np_rearm,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_class,
  input  logic              req_has_data,
  input  logic [LEN_W-1:0]  req_len,
  output logic              stall
);
  localparam int NEED_W = LEN_W - 1;

  logic [NEED_W-1:0]      need;
  logic [NUM_CLASSES-1:0] pass;
  logic [3:0]             pass_by_code;
  logic                   credit_ok;
  logic                   req_np;

  txc_need #(.LEN_W(LEN_W)) u_need (
    .len  (req_len),
    .need (need)
  );

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    localparam int DW = txc_dat_w(c);
    localparam int HL = txc_hdr_lo(c);
    localparam int DL = txc_dat_lo(c);

    txc_class_check #(
      .HDR_W  (HDR_W),
      .DATA_W (DW),
      .NEED_W (NEED_W),
      .FLOOR  (NP_FLOOR)
    ) u_chk (
      .hdr_fld   (tx_credits[HL +: HDR_W]),
      .dat_fld   (tx_credits[DL +: DW]),
      .need      (need),
      .has_data  (req_has_data),
      .strict_en ((c == 1) ? np_strict : 1'b0),
      .pass      (pass[c])
    );
  end

  always_comb begin
    pass_by_code = {1'b0, pass};
    credit_ok    = pass_by_code[req_class];
    req_np       = (req_class == TXC_NONPOST);
  end

  txc_grant_ctl #(.NP_ONE_CREDIT(NP_ONE_CREDIT)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_np    (req_np),
    .credit_ok (credit_ok),
    .np_rearm  (np_rearm),
    .grant     (req_ready)
  );

  assign stall = req_valid && !req_ready;
endmodule

// File: rtl/txc_gate_chk.sv
module txc_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [1:0]  req_class,
  input logic        req_has_data,
  input logic [14:0] pst_cred
);
  // R8: a grant without a transfer is kept
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && !req_valid |=> req_ready);

  // R8: a transfer is followed by a cycle without grant
  p_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && req_valid |=> !req_ready);

  // R6: reserved class is never granted
  p_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && req_valid && req_class == 2'd3 |=> !req_ready);

  // R2: no posted header credit, no posted grant
  p_nohdr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && req_valid && req_class == 2'd0 && pst_cred[2:0] == 3'd0
    |=> !req_ready);

  // R4: infinite posted credit always grants on the next edge
  p_inf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && req_valid && req_class == 2'd0 && pst_cred[2:0] == 3'd7 &&
    (!req_has_data || pst_cred[14:3] == 12'hFFF) |=> req_ready);
endmodule

bind txc_gate txc_gate_chk u_gate_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_class    (req_class),
  .req_has_data (req_has_data),
  .pst_cred     (tx_credits[14:0])
);

// File: tb/txc_gate_tb.sv
`timescale 1ns/1ps
module txc_gate_tb;
  localparam int LEN_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [35:0]      tx_credits = '0;
  logic             np_strict = 1'b0;
  logic             np_rearm = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [1:0]       req_class = 2'd0;
  logic             req_has_data = 1'b0;
  logic [LEN_W-1:0] req_len = '0;
  logic             stall;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  txc_gate #(.LEN_W(LEN_W), .NP_FLOOR(6), .NP_ONE_CREDIT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_credits(tx_credits), .np_strict(np_strict),
    .np_rearm(np_rearm), .req_valid(req_valid), .req_ready(req_ready),
    .req_class(req_class), .req_has_data(req_has_data), .req_len(req_len),
    .stall(stall)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [35:0] mk(int cls, int hv, int dv);
    logic [35:0] v = '0;
    case (cls)
      1:       begin v[17:15] = 3'(hv); v[20:18] = 3'(dv);  end
      2:       begin v[23:21] = 3'(hv); v[35:24] = 12'(dv); end
      default: begin v[2:0]   = 3'(hv); v[14:3]  = 12'(dv); end
    endcase
    return v;
  endfunction

  function automatic bit exp_ok(int cls, bit hd, bit st, int hv, int dv, int len);
    int need = (len + 3) / 4;
    bit strict = st && (cls == 1);
    bit dinf = (cls == 1) ? (dv == 7) : (dv == 4095);
    bit hok, dok;
    if (cls == 3) return 1'b0;
    hok = (hv == 7) || (strict ? (hv >= 6) : (hv != 0));
    dok = !hd || dinf || ((!strict || dv >= 6) && dv >= need);
    return hok && dok;
  endfunction

  task automatic run_one(int cls, bit hd, bit st, int hv, int dv, int len);
    bit e = exp_ok(cls, hd, st, hv, dv, len);
    string tag;
    if (cls == 3)                  tag = "R6 reserved";
    else if (st && cls == 1)       tag = "R5 strict";
    else if (hv == 7 || (hd && dv == ((cls == 1) ? 7 : 4095))) tag = "R4 infinite";
    else if (hd)                   tag = "R3 data need";
    else                           tag = "R2 header";
    @(negedge clk);
    tx_credits = mk(cls, hv, dv); req_class = 2'(cls); req_has_data = hd;
    req_len = LEN_W'(len); np_strict = st; req_valid = 1'b1;
    @(negedge clk);
    check(req_ready === e, {"R1 ", tag}, int'(req_ready), int'(e));
    check(stall === !e, "R10 stall", int'(stall), int'(!e));
    if (e) begin
      @(negedge clk);
      check(req_ready === 1'b0, "R8 drop after transfer", int'(req_ready), 0);
    end
    req_valid = 1'b0; np_rearm = 1'b1;
    @(negedge clk);
    np_rearm = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int wide [8] = '{0, 1, 3, 4, 7, 15, 16, 4095};
    int lens [11] = '{0, 1, 3, 4, 5, 8, 13, 16, 17, 33, 63};

    repeat (3) @(negedge clk);
    check(req_ready === 1'b0, "R10 reset ready", int'(req_ready), 0);
    check(stall === 1'b0, "R10 reset stall", int'(stall), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: grant appears only after the edge
    tx_credits = mk(0, 7, 0); req_class = 2'd0; req_has_data = 1'b0; req_valid = 1'b1;
    #1 check(req_ready === 1'b0, "R7 before edge", int'(req_ready), 0);
    @(negedge clk);
    check(req_ready === 1'b1, "R7 after edge", int'(req_ready), 1);
    // R8: hold while valid is withdrawn and credits vanish
    req_valid = 1'b0; tx_credits = '0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(req_ready === 1'b1, "R8 hold", int'(req_ready), 1);
    end
    req_valid = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b0, "R8 cleared by transfer", int'(req_ready), 0);
    req_valid = 1'b0;
    @(negedge clk);

    // R9: single non-posted credit
    tx_credits = mk(1, 7, 7) | mk(0, 7, 0); req_class = 2'd1; req_valid = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1, "R9 first non-posted", int'(req_ready), 1);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(req_ready === 1'b0, "R9 blocked", int'(req_ready), 0);
      check(stall === 1'b1, "R9 stall while blocked", int'(stall), 1);
    end
    req_class = 2'd0;
    @(negedge clk);
    check(req_ready === 1'b1, "R9 posted passes", int'(req_ready), 1);
    @(negedge clk);
    req_class = 2'd1; np_rearm = 1'b1;
    @(negedge clk);
    np_rearm = 1'b0;
    check(req_ready === 1'b0, "R9 rearm takes a cycle", int'(req_ready), 0);
    @(negedge clk);
    check(req_ready === 1'b1, "R9 rearmed", int'(req_ready), 1);
    np_rearm = 1'b1;
    @(negedge clk);
    np_rearm = 1'b0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check(req_ready === 1'b0, "R9 transfer beats rearm", int'(req_ready), 0);
    end
    req_valid = 1'b0; np_rearm = 1'b1;
    @(negedge clk);
    np_rearm = 1'b0;

    // Sweep of classes, flags, header values, data values and lengths
    for (int cls = 0; cls < 4; cls++)
      for (int hd = 0; hd < 2; hd++)
        for (int st = 0; st < 2; st++)
          for (int hv = 0; hv < 8; hv++)
            for (int di = 0; di < 8; di++)
              for (int li = 0; li < 11; li++) begin
                if (!hd && li > 0) continue;
                run_one(cls, hd[0], st[0], hv, (cls == 1) ? di : wide[di], lens[li]);
              end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule